// File: doc/BRIEF.md
# Memory-Card Host Register Front End

This block is the software-visible register file of a memory-card host controller. It sits on a simple 32-bit bus with separate write and read enables and a byte offset. It stores the configuration words that the rest of the controller consumes: power, card clock, command argument, command, data timer, data length and data control. It also keeps an 11-bit event status word. Hardware raises bits in that word, and software clears them by writing ones. Two interrupt mask words each gate the status into an interrupt line.

Writes with side effects turn into single-cycle strobes for the engines behind the block. A command write that has the launch bit set fires a command start. A data-control write that has the enable bit set copies the length into a remaining-byte counter and kicks the data engine. Sixteen consecutive word offsets form a window onto the data FIFO. A write there becomes a push strobe that carries the word, but only while bytes remain to be moved. A read there returns the word the FIFO presents and pops it. The data engine counts bytes down through a decrement input, and the command engine reports completion through a done input, which clears the launch bit.

Top module: `cardhost_regif`

## Requirements
- R1: After reset every stored register, the status word and the remaining-byte count are zero. All strobes and both interrupt lines are low, and `rdData` is zero.
- R2: Register offsets are as follows. Power (0x00), clock (0x04) and data control (0x2C) keep the low 8 bits written. Data length (0x28) keeps the low 16 bits. Argument (0x08), command (0x0C), data timer (0x24) and the masks at 0x3C and 0x40 keep all 32 bits. A read returns the stored value zero-extended.
- R3: A write to 0x0C with bit 10 set pulses `cmdStart` high for exactly the one cycle after the write edge. A write with bit 10 clear stores the value and does not pulse.
- R4: A `cmdDone` cycle clears bit 10 of the command register and keeps its other bits. A command write in the same cycle as `cmdDone` stores the written value unchanged.
- R5: A write to 0x2C with bit 0 set loads the remaining-byte count from the data length register and pulses `dataKick` for one cycle. With bit 0 clear, the count is untouched.
- R6: Each `byteTake` cycle decrements the remaining count, which stops at zero. A count load in the same cycle wins over the decrement. The count is output on `remCount` and readable at 0x30.
- R7: A write to any of the 16 word offsets 0x80 to 0xBC behaves in one of two ways. If the remaining count is non-zero, it pulses `fifoPush` and `dataKick` and presents the word on `fifoWrWord`. If the count is zero, it pulses `fifoErr` only.
- R8: A read of the FIFO window returns `fifoRdWord` as sampled in the read cycle and pulses `fifoPop` for one cycle.
- R9: The 11-bit status (read at 0x34) ORs in `statusSet` each cycle. A write to 0x38 clears each status bit whose data bit is 1 among bits 10:0. When a bit is set and cleared in the same cycle, the set wins.
- R10: `irqOut[i]` is high exactly when the status ANDed with the low 11 bits of mask i (mask 0 at 0x3C, mask 1 at 0x40) is non-zero.
- R11: A write to an unmapped, read-only (0x30, 0x34) or misaligned offset pulses `addrErr` and changes no register. Reads of unmapped offsets and of 0x38 return zero.
- R12: Read data appears on `rdData` in the cycle after `rdEn` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write enable |
| rdEn | input | 1 | Bus read enable |
| addr | input | 8 | Byte offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| cmdStart | output | 1 | Command launch strobe |
| cmdDone | input | 1 | Command engine completion |
| dataKick | output | 1 | Data engine start strobe |
| byteTake | input | 1 | Decrement remaining-byte count |
| remCount | output | 16 | Remaining-byte count |
| fifoPush | output | 1 | FIFO push strobe |
| fifoWrWord | output | 32 | Word for the push |
| fifoPop | output | 1 | FIFO pop strobe |
| fifoRdWord | input | 32 | FIFO head word |
| statusSet | input | 11 | Status bits to raise |
| irqOut | output | 2 | Masked status lines |
| addrErr | output | 1 | Bad-offset write strobe |
| fifoErr | output | 1 | Rejected FIFO write strobe |

## Verification
Two status paths can land in one cycle: a hardware raise through `statusSet` and a software clear through a write to 0x38 that covers the same bit. The bench drives both on the same falling edge and reads the status back, expecting the raised bit to survive while the other cleared bits drop. The same approach is used for a command write coinciding with `cmdDone`, and for a count load coinciding with `byteTake`. In each case the written value must win.

// File: rtl/cardhost_regif_pkg.sv
package cardhost_regif_pkg;

  localparam int NUM_MASKS = 2;

  localparam int OFF_POWER     = 'h00;
  localparam int OFF_CLOCK     = 'h04;
  localparam int OFF_ARG       = 'h08;
  localparam int OFF_CMD       = 'h0C;
  localparam int OFF_TIMER     = 'h24;
  localparam int OFF_LEN       = 'h28;
  localparam int OFF_DCTRL     = 'h2C;
  localparam int OFF_REM       = 'h30;
  localparam int OFF_STATUS    = 'h34;
  localparam int OFF_CLEAR     = 'h38;
  localparam int OFF_MASK_BASE = 'h3C;
  localparam int OFF_FIFO_BASE = 'h80;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_POWER,
    SEL_CLOCK,
    SEL_ARG,
    SEL_CMD,
    SEL_TIMER,
    SEL_LEN,
    SEL_DCTRL,
    SEL_REM,
    SEL_STATUS,
    SEL_CLEAR,
    SEL_MASK,
    SEL_FIFO
  } regSel_e;

  typedef struct packed {
    regSel_e                rdSel;
    logic                   rdEn;
    logic                   wrPower;
    logic                   wrClock;
    logic                   wrArg;
    logic                   wrCmd;
    logic                   wrTimer;
    logic                   wrLen;
    logic                   wrDctrl;
    logic                   dataLoad;
    logic                   wrClear;
    logic [NUM_MASKS-1:0]   maskHit;
    logic [NUM_MASKS-1:0]   wrMask;
    logic                   fifoPushOk;
    logic                   fifoReject;
    logic                   addrBad;
    logic                   fifoPopRd;
  } regStrobes_t;

endpackage

// File: rtl/cardhost_regif_ctrl.sv
module cardhost_regif_ctrl
  import cardhost_regif_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int FIFO_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cmdEnBit,
  input  logic              dataEnBit,
  input  logic              remZero,
  output regStrobes_t       stb,
  output logic              cmdStart,
  output logic              dataKick,
  output logic              fifoPush,
  output logic              fifoPop,
  output logic              addrErr,
  output logic              fifoErr
);

  localparam int FIFO_LO = OFF_FIFO_BASE;
  localparam int FIFO_HI = OFF_FIFO_BASE + 4 * (FIFO_WORDS - 1);

  regSel_e              sel;
  logic [NUM_MASKS-1:0] maskHit;
  int                   offVal;

  always_comb begin
    offVal  = int'(addr);
    sel     = SEL_NONE;
    maskHit = '0;
    if (addr[1:0] != 2'b00) begin
      sel = SEL_NONE;
    end else if (offVal >= FIFO_LO && offVal <= FIFO_HI) begin
      sel = SEL_FIFO;
    end else begin
      case (offVal)
        OFF_POWER:  sel = SEL_POWER;
        OFF_CLOCK:  sel = SEL_CLOCK;
        OFF_ARG:    sel = SEL_ARG;
        OFF_CMD:    sel = SEL_CMD;
        OFF_TIMER:  sel = SEL_TIMER;
        OFF_LEN:    sel = SEL_LEN;
        OFF_DCTRL:  sel = SEL_DCTRL;
        OFF_REM:    sel = SEL_REM;
        OFF_STATUS: sel = SEL_STATUS;
        OFF_CLEAR:  sel = SEL_CLEAR;
        default:    sel = SEL_NONE;
      endcase
      for (int i = 0; i < NUM_MASKS; i++) begin
        if (offVal == OFF_MASK_BASE + 4 * i) begin
          sel        = SEL_MASK;
          maskHit[i] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    stb            = '0;
    stb.rdSel      = sel;
    stb.rdEn       = rdEn;
    stb.maskHit    = maskHit;
    stb.wrPower    = wrEn && sel == SEL_POWER;
    stb.wrClock    = wrEn && sel == SEL_CLOCK;
    stb.wrArg      = wrEn && sel == SEL_ARG;
    stb.wrCmd      = wrEn && sel == SEL_CMD;
    stb.wrTimer    = wrEn && sel == SEL_TIMER;
    stb.wrLen      = wrEn && sel == SEL_LEN;
    stb.wrDctrl    = wrEn && sel == SEL_DCTRL;
    stb.dataLoad   = wrEn && sel == SEL_DCTRL && dataEnBit;
    stb.wrClear    = wrEn && sel == SEL_CLEAR;
    stb.wrMask     = wrEn ? maskHit : '0;
    stb.fifoPushOk = wrEn && sel == SEL_FIFO && !remZero;
    stb.fifoReject = wrEn && sel == SEL_FIFO && remZero;
    stb.addrBad    = wrEn && (sel == SEL_NONE || sel == SEL_REM || sel == SEL_STATUS);
    stb.fifoPopRd  = rdEn && sel == SEL_FIFO;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdStart <= 1'b0;
      dataKick <= 1'b0;
      fifoPush <= 1'b0;
      fifoPop  <= 1'b0;
      addrErr  <= 1'b0;
      fifoErr  <= 1'b0;
    end else begin
      cmdStart <= stb.wrCmd && cmdEnBit;
      dataKick <= stb.dataLoad || stb.fifoPushOk;
      fifoPush <= stb.fifoPushOk;
      fifoPop  <= stb.fifoPopRd;
      addrErr  <= stb.addrBad;
      fifoErr  <= stb.fifoReject;
    end
  end

endmodule

// File: rtl/cardhost_regif_dp.sv
module cardhost_regif_dp
  import cardhost_regif_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int STAT_W     = 11,
  parameter int BYTE_W     = 8,
  parameter int CMD_EN_BIT = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobes_t          stb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [DATA_W-1:0]    fifoRdWord,
  input  logic                 cmdDone,
  input  logic                 byteTake,
  input  logic [STAT_W-1:0]    statusSet,
  output logic [DATA_W-1:0]    rdData,
  output logic [DATA_W-1:0]    fifoWrWord,
  output logic [LEN_W-1:0]     remCount,
  output logic [LEN_W-1:0]     lenVal,
  output logic [STAT_W-1:0]    statusVal,
  output logic                 remZero,
  output logic [NUM_MASKS-1:0] irqOut
);

  localparam int BYTE_PAD = DATA_W - BYTE_W;
  localparam int LEN_PAD  = DATA_W - LEN_W;
  localparam int STAT_PAD = DATA_W - STAT_W;

  logic [BYTE_W-1:0] powerReg;
  logic [BYTE_W-1:0] clockReg;
  logic [DATA_W-1:0] argReg;
  logic [DATA_W-1:0] cmdReg;
  logic [DATA_W-1:0] timerReg;
  logic [LEN_W-1:0]  lenReg;
  logic [BYTE_W-1:0] dctrlReg;
  logic [LEN_W-1:0]  remReg;
  logic [STAT_W-1:0] statusReg;
  logic [DATA_W-1:0] maskReg [NUM_MASKS];
  logic [DATA_W-1:0] rdMux;
  logic [DATA_W-1:0] maskRd;
  logic [STAT_W-1:0] clearBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      powerReg <= '0;
      clockReg <= '0;
      argReg   <= '0;
      timerReg <= '0;
      lenReg   <= '0;
      dctrlReg <= '0;
    end else begin
      if (stb.wrPower) powerReg <= wrData[BYTE_W-1:0];
      if (stb.wrClock) clockReg <= wrData[BYTE_W-1:0];
      if (stb.wrArg)   argReg   <= wrData;
      if (stb.wrTimer) timerReg <= wrData;
      if (stb.wrLen)   lenReg   <= wrData[LEN_W-1:0];
      if (stb.wrDctrl) dctrlReg <= wrData[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (stb.wrCmd) begin
      cmdReg <= wrData;
    end else if (cmdDone) begin
      cmdReg[CMD_EN_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg <= '0;
    end else if (stb.dataLoad) begin
      remReg <= lenReg;
    end else if (byteTake && remReg != '0) begin
      remReg <= remReg - 1'b1;
    end
  end

  assign clearBits = stb.wrClear ? wrData[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= '0;
    end else begin
      statusReg <= (statusReg & ~clearBits) | statusSet;
    end
  end

  for (genvar g = 0; g < NUM_MASKS; g++) begin : gMask
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskReg[g] <= '0;
      end else if (stb.wrMask[g]) begin
        maskReg[g] <= wrData;
      end
    end
    assign irqOut[g] = |(statusReg & maskReg[g][STAT_W-1:0]);
  end

  always_comb begin
    maskRd = '0;
    for (int i = 0; i < NUM_MASKS; i++) begin
      if (stb.maskHit[i]) maskRd = maskRd | maskReg[i];
    end
  end

  always_comb begin
    case (stb.rdSel)
      SEL_POWER:  rdMux = {{BYTE_PAD{1'b0}}, powerReg};
      SEL_CLOCK:  rdMux = {{BYTE_PAD{1'b0}}, clockReg};
      SEL_ARG:    rdMux = argReg;
      SEL_CMD:    rdMux = cmdReg;
      SEL_TIMER:  rdMux = timerReg;
      SEL_LEN:    rdMux = {{LEN_PAD{1'b0}}, lenReg};
      SEL_DCTRL:  rdMux = {{BYTE_PAD{1'b0}}, dctrlReg};
      SEL_REM:    rdMux = {{LEN_PAD{1'b0}}, remReg};
      SEL_STATUS: rdMux = {{STAT_PAD{1'b0}}, statusReg};
      SEL_MASK:   rdMux = maskRd;
      SEL_FIFO:   rdMux = fifoRdWord;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdEn) begin
      rdData <= rdMux;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoWrWord <= '0;
    end else if (stb.fifoPushOk) begin
      fifoWrWord <= wrData;
    end
  end

  assign remCount  = remReg;
  assign lenVal    = lenReg;
  assign statusVal = statusReg;
  assign remZero   = (remReg == '0);

endmodule

// File: rtl/cardhost_regif.sv
module cardhost_regif
  import cardhost_regif_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 16,
  parameter int STAT_W      = 11,
  parameter int BYTE_W      = 8,
  parameter int FIFO_WORDS  = 16,
  parameter int CMD_EN_BIT  = 10,
  parameter int DATA_EN_BIT = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 cmdStart,
  input  logic                 cmdDone,
  output logic                 dataKick,
  input  logic                 byteTake,
  output logic [LEN_W-1:0]     remCount,
  output logic                 fifoPush,
  output logic [DATA_W-1:0]    fifoWrWord,
  output logic                 fifoPop,
  input  logic [DATA_W-1:0]    fifoRdWord,
  input  logic [STAT_W-1:0]    statusSet,
  output logic [NUM_MASKS-1:0] irqOut,
  output logic                 addrErr,
  output logic                 fifoErr
);

  regStrobes_t       stb;
  logic              remZero;
  logic [LEN_W-1:0]  lenVal;
  logic [STAT_W-1:0] statusVal;

  cardhost_regif_ctrl #(
    .ADDR_W    (ADDR_W),
    .FIFO_WORDS(FIFO_WORDS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .addr     (addr),
    .cmdEnBit (wrData[CMD_EN_BIT]),
    .dataEnBit(wrData[DATA_EN_BIT]),
    .remZero  (remZero),
    .stb      (stb),
    .cmdStart (cmdStart),
    .dataKick (dataKick),
    .fifoPush (fifoPush),
    .fifoPop  (fifoPop),
    .addrErr  (addrErr),
    .fifoErr  (fifoErr)
  );

  cardhost_regif_dp #(
    .DATA_W    (DATA_W),
    .LEN_W     (LEN_W),
    .STAT_W    (STAT_W),
    .BYTE_W    (BYTE_W),
    .CMD_EN_BIT(CMD_EN_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .fifoRdWord(fifoRdWord),
    .cmdDone   (cmdDone),
    .byteTake  (byteTake),
    .statusSet (statusSet),
    .rdData    (rdData),
    .fifoWrWord(fifoWrWord),
    .remCount  (remCount),
    .lenVal    (lenVal),
    .statusVal (statusVal),
    .remZero   (remZero),
    .irqOut    (irqOut)
  );

endmodule

// File: rtl/cardhost_regif_chk.sv
module cardhost_regif_chk
  import cardhost_regif_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 16,
  parameter int STAT_W      = 11,
  parameter int FIFO_WORDS  = 16,
  parameter int CMD_EN_BIT  = 10,
  parameter int DATA_EN_BIT = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              cmdStart,
  input logic              byteTake,
  input logic [LEN_W-1:0]  remCount,
  input logic [LEN_W-1:0]  lenVal,
  input logic [STAT_W-1:0] statusVal,
  input logic [STAT_W-1:0] statusSet,
  input logic              fifoPush,
  input logic              fifoPop,
  input logic              fifoErr,
  input logic              addrErr
);

  logic fifoHit;
  logic dataLoadWr;
  logic cmdLaunchWr;

  assign fifoHit = addr[1:0] == 2'b00 && int'(addr) >= OFF_FIFO_BASE &&
                   int'(addr) <= OFF_FIFO_BASE + 4 * (FIFO_WORDS - 1);
  assign dataLoadWr  = wrEn && int'(addr) == OFF_DCTRL && wrData[DATA_EN_BIT];
  assign cmdLaunchWr = wrEn && int'(addr) == OFF_CMD && wrData[CMD_EN_BIT];

  a_r3_start_from_write: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> $past(cmdLaunchWr));

  a_r5_count_load: assert property (@(posedge clk) disable iff (!rstN)
    dataLoadWr |=> remCount == $past(lenVal));

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (byteTake && !dataLoadWr && remCount != '0) |=> remCount == $past(remCount) - 1'b1);

  a_r6_count_floor: assert property (@(posedge clk) disable iff (!rstN)
    (!dataLoadWr && remCount == '0) |=> remCount == '0);

  a_r7_push_or_reject: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoPush && fifoErr));

  a_r7_reject_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && fifoHit && remCount == '0) |=> (fifoErr && !fifoPush));

  a_r8_pop_from_read: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> $past(rdEn && fifoHit));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (statusSet != '0) |=> (statusVal & $past(statusSet)) == $past(statusSet));

  a_r11_err_from_write: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> $past(wrEn));

endmodule

bind cardhost_regif cardhost_regif_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .LEN_W      (LEN_W),
  .STAT_W     (STAT_W),
  .FIFO_WORDS (FIFO_WORDS),
  .CMD_EN_BIT (CMD_EN_BIT),
  .DATA_EN_BIT(DATA_EN_BIT)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .addr     (addr),
  .wrData   (wrData),
  .cmdStart (cmdStart),
  .byteTake (byteTake),
  .remCount (remCount),
  .lenVal   (lenVal),
  .statusVal(statusVal),
  .statusSet(statusSet),
  .fifoPush (fifoPush),
  .fifoPop  (fifoPop),
  .fifoErr  (fifoErr),
  .addrErr  (addrErr)
);

// File: tb/cardhost_regif_tb.sv
`timescale 1ns/1ps
module cardhost_regif_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        cmdStart;
  logic        cmdDone = 1'b0;
  logic        dataKick;
  logic        byteTake = 1'b0;
  logic [15:0] remCount;
  logic        fifoPush;
  logic [31:0] fifoWrWord;
  logic        fifoPop;
  logic [31:0] fifoRdWord = '0;
  logic [10:0] statusSet = '0;
  logic [1:0]  irqOut;
  logic        addrErr;
  logic        fifoErr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cardhost_regif u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .cmdStart(cmdStart), .cmdDone(cmdDone),
    .dataKick(dataKick), .byteTake(byteTake), .remCount(remCount),
    .fifoPush(fifoPush), .fifoWrWord(fifoWrWord), .fifoPop(fifoPop),
    .fifoRdWord(fifoRdWord), .statusSet(statusSet), .irqOut(irqOut),
    .addrErr(addrErr), .fifoErr(fifoErr)
  );

  typedef struct packed {
    logic        isWr;
    logic [7:0]  off;
    logic [31:0] data;
    logic [31:0] expVal;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h00, 32'h1234_56AB, 32'h0},
    '{1'b0, 8'h00, 32'h0,         32'h0000_00AB},
    '{1'b1, 8'h04, 32'hFFFF_FF3C, 32'h0},
    '{1'b0, 8'h04, 32'h0,         32'h0000_003C},
    '{1'b1, 8'h08, 32'hDEAD_BEEF, 32'h0},
    '{1'b0, 8'h08, 32'h0,         32'hDEAD_BEEF},
    '{1'b1, 8'h24, 32'h0BAD_F00D, 32'h0},
    '{1'b0, 8'h24, 32'h0,         32'h0BAD_F00D},
    '{1'b1, 8'h28, 32'hABCD_0040, 32'h0},
    '{1'b0, 8'h28, 32'h0,         32'h0000_0040},
    '{1'b1, 8'h2C, 32'h0000_0F02, 32'h0},
    '{1'b0, 8'h2C, 32'h0,         32'h0000_0002},
    '{1'b0, 8'h30, 32'h0,         32'h0000_0000},
    '{1'b1, 8'h3C, 32'h0000_0005, 32'h0},
    '{1'b0, 8'h3C, 32'h0,         32'h0000_0005},
    '{1'b1, 8'h40, 32'hF000_0402, 32'h0},
    '{1'b0, 8'h40, 32'h0,         32'hF000_0402},
    '{1'b1, 8'h0C, 32'h0000_0123, 32'h0},
    '{1'b0, 8'h0C, 32'h0,         32'h0000_0123},
    '{1'b0, 8'h10, 32'h0,         32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, expv);
    end
  endtask

  // Drive at a falling edge; return at the next falling edge, where registered strobes are visible.
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // R12: data captured at the edge after rdEn, visible at the following falling edge.
  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdData", rdData, 32'h0);
    check("R1 strobes", {26'h0, cmdStart, dataKick, fifoPush, fifoPop, addrErr, fifoErr}, 32'h0);
    check("R1 irq", {30'h0, irqOut}, 32'h0);
    check("R1 remCount", {16'h0, remCount}, 32'h0);
    busRead(8'h34, rv); check("R1 status", rv, 32'h0);
    busRead(8'h0C, rv); check("R1 cmd", rv, 32'h0);

    // R2 R11 R12 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].isWr) begin
        busWrite(VEC[i].off, VEC[i].data);
        check("R2 no addrErr on mapped write", {31'h0, addrErr}, 32'h0);
        check("R3 no start without launch bit", {31'h0, cmdStart}, 32'h0);
      end else begin
        busRead(VEC[i].off, rv);
        check("R2/R11 read value", rv, VEC[i].expVal);
      end
    end
    check("R5 no load without enable", {16'h0, remCount}, 32'h0);

    // R3 launch strobe
    busWrite(8'h0C, 32'h0000_0405);
    check("R3 cmdStart pulse", {31'h0, cmdStart}, 32'h1);
    @(negedge clk);
    check("R3 cmdStart single cycle", {31'h0, cmdStart}, 32'h0);
    busRead(8'h0C, rv); check("R3 cmd stored", rv, 32'h0000_0405);

    // R4 done clears launch bit
    @(negedge clk); cmdDone = 1'b1;
    @(negedge clk); cmdDone = 1'b0;
    busRead(8'h0C, rv); check("R4 launch bit cleared", rv, 32'h0000_0005);
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h0C; wrData = 32'h0000_0405; cmdDone = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; cmdDone = 1'b0;
    busRead(8'h0C, rv); check("R4 write beats done", rv, 32'h0000_0405);

    // R5 count load
    busWrite(8'h2C, 32'h0000_0001);
    check("R5 dataKick", {31'h0, dataKick}, 32'h1);
    check("R5 count loaded", {16'h0, remCount}, 32'h0000_0040);
    busRead(8'h30, rv); check("R6 count readable", rv, 32'h0000_0040);

    // R6 decrement and load priority
    @(negedge clk); byteTake = 1'b1;
    repeat (3) @(negedge clk);
    byteTake = 1'b0;
    check("R6 decrement", {16'h0, remCount}, 32'h0000_003D);
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h2C; wrData = 32'h0000_0001; byteTake = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; byteTake = 1'b0;
    check("R6 load beats decrement", {16'h0, remCount}, 32'h0000_0040);
    busWrite(8'h28, 32'h0000_0002);
    busWrite(8'h2C, 32'h0000_0001);
    @(negedge clk); byteTake = 1'b1;
    repeat (3) @(negedge clk);
    byteTake = 1'b0;
    check("R6 stops at zero", {16'h0, remCount}, 32'h0);

    // R7 FIFO window writes
    busWrite(8'h84, 32'h1111_2222);
    check("R7 reject flagged", {31'h0, fifoErr}, 32'h1);
    check("R7 reject no push", {31'h0, fifoPush}, 32'h0);
    check("R7 reject no kick", {31'h0, dataKick}, 32'h0);
    busWrite(8'h28, 32'h0000_0008);
    busWrite(8'h2C, 32'h0000_0001);
    busWrite(8'hBC, 32'hCAFE_F00D);
    check("R7 push", {31'h0, fifoPush}, 32'h1);
    check("R7 push word", fifoWrWord, 32'hCAFE_F00D);
    check("R7 push kick", {31'h0, dataKick}, 32'h1);
    check("R7 push no error", {31'h0, fifoErr}, 32'h0);
    busWrite(8'hC0, 32'h0BAD_0BAD);
    check("R11 past window addrErr", {31'h0, addrErr}, 32'h1);
    check("R11 past window no push", {31'h0, fifoPush}, 32'h0);
    busWrite(8'h86, 32'h0BAD_0BAD);
    check("R11 misaligned addrErr", {31'h0, addrErr}, 32'h1);

    // R8 FIFO window read
    fifoRdWord = 32'h55AA_1234;
    busRead(8'h90, rv);
    check("R8 read word", rv, 32'h55AA_1234);
    check("R8 pop", {31'h0, fifoPop}, 32'h1);
    @(negedge clk);
    check("R8 pop single cycle", {31'h0, fifoPop}, 32'h0);

    // R9 R10 status and masks
    @(negedge clk); statusSet = 11'h0F3;
    @(negedge clk); statusSet = '0;
    busRead(8'h34, rv); check("R9 status set", rv, 32'h0000_00F3);
    check("R10 both lines", {30'h0, irqOut}, 32'h3);
    busWrite(8'h38, 32'hFFFF_F003);
    busRead(8'h34, rv); check("R9 clear", rv, 32'h0000_00F0);
    check("R10 lines drop", {30'h0, irqOut}, 32'h0);
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h38; wrData = 32'h0000_00F0; statusSet = 11'h010;
    @(negedge clk);
    wrEn = 1'b0; statusSet = '0;
    busRead(8'h34, rv); check("R9 set wins", rv, 32'h0000_0010);
    @(negedge clk); statusSet = 11'h400;
    @(negedge clk); statusSet = '0;
    check("R10 line1 only", {30'h0, irqOut}, 32'h2);
    busRead(8'h38, rv); check("R11 clear reads zero", rv, 32'h0);

    // R11 bad writes
    busWrite(8'h34, 32'h0000_07FF);
    check("R11 read-only addrErr", {31'h0, addrErr}, 32'h1);
    busRead(8'h34, rv); check("R11 status untouched", rv, 32'h0000_0410);
    busWrite(8'h14, 32'hFFFF_FFFF);
    check("R11 unmapped addrErr", {31'h0, addrErr}, 32'h1);
    busRead(8'h00, rv); check("R11 power untouched", rv, 32'h0000_00AB);
    @(negedge clk);
    check("R11 addrErr single cycle", {31'h0, addrErr}, 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule